// File: doc/BRIEF.md
# Generalised Reverse LUT Unit

This unit is a 64-bit butterfly datapath for a scalar bit-manipulation pipeline. It runs a network of six stages, one per bit of a control word. In an enabled stage, each bit pairs with the bit whose position differs only in that stage's bit. The bit is then replaced by a 2-input lookup of the pair. The lookup table is programmable from an 8-bit immediate: one nibble serves the lower member of every pair and the other nibble serves the upper member. The same hardware therefore performs generalised reverse, generalised OR-combine and many other per-stage functions.

The starting word is either the source operand or, when the source names the zero register, a built-in alternating constant. The starting word can be complemented first. Together with the seed, this lets a single operation produce regular mask patterns such as one set bit per nibble, byte or halfword. The result is registered: a strobe on `in_valid` gives a result and `out_valid` on the next clock.

Top module: `grev_lut_unit`

## Requirements
- R1: While reset is asserted and after it is released with no strobe, `out_valid` is 0 and `result` is all zeros.
- R2: When `in_valid` is 1 at a rising edge, `out_valid` is 1 after that edge and `result` holds the value computed from the inputs sampled at that edge. Otherwise `out_valid` is 0 after the edge.
- R3: A rising edge with `in_valid` at 0 leaves `result` unchanged, whatever the other inputs do.
- R4: The starting word is the constant 0x5555_5555_5555_5555 (bit 0 set) when `src_is_zero` is 1, and `src_word` otherwise.
- R5: When `invert` is 1, the starting word is complemented before the first stage. A zero-register source then starts from 0xAAAA_AAAA_AAAA_AAAA.
- R6: Stage k (k = 0..5) is active when `stage_ctl[k]` is 1. In it, bit j pairs with bit j XOR 2^k. The stages apply in order of increasing k.
- R7: In an active stage, the table index is 2*L + U, where L is the pair's lower-position bit and U its upper-position bit. A lower-position bit (j & 2^k == 0) becomes `lut_imm[idx]`. An upper-position bit becomes `lut_imm[4+idx]`.
- R8: With `lut_imm` = 0xCA, the result equals the plain generalised reverse of the starting word under `stage_ctl`.
- R9: With `lut_imm` = 0xEE, the result equals the generalised OR-combine of the starting word under `stage_ctl`.
- R10: With a zero-register source, `invert` = 0 and `lut_imm` = 0x6C, control values 0x02, 0x06 and 0x0E give 0x1111..., 0x0101... and 0x0001_0001.... With `invert` = 1 and `lut_imm` = 0xC6, the same control values give 0x8888..., 0x8080... and 0x8000_8000....
- R11: With `stage_ctl` = 0, the result is the starting word for every immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| src_word | input | 64 | Source operand |
| src_is_zero | input | 1 | Source is the zero register; use the constant seed |
| stage_ctl | input | 6 | Stage enable per bit, bit k enables chunk size 2^k |
| lut_imm | input | 8 | Two LUT2 tables: [3:0] lower positions, [7:4] upper positions |
| invert | input | 1 | Complement the starting word |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Registered result |

## Verification
The hardest case to reach from the ports is a swapped index order inside a single stage. Such a fault is invisible to any immediate whose two nibbles are symmetric in their index bits, and to every control word that leaves that stage off. The bench therefore sweeps all 256 immediates against all 64 control words. The source, seed flag and invert flag come from a generator, and a bit-by-bit table model gives the expected values. Separate sweeps compare the 0xCA and 0xEE immediates against shift-and-mask reverse and OR-combine formulas, so the index convention is also pinned by an arithmetic model that uses no tables.

// File: rtl/grev_lut_pkg.sv
package grev_lut_pkg;
    localparam int WORD_W  = 64;
    localparam int STAGE_N = $clog2(WORD_W);
    localparam int IMM_W   = 8;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } out_state_t;
endpackage

// File: rtl/grev_lut_seed.sv
module grev_lut_seed #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] src_word,
    input  logic             src_is_zero,
    input  logic             invert,
    output logic [WIDTH-1:0] seed
);
    localparam int PAIRS = WIDTH / 2;
    localparam logic [WIDTH-1:0] ALT_CONST = {PAIRS{2'b01}};

    logic [WIDTH-1:0] base;

    always_comb begin
        base = src_is_zero ? ALT_CONST : src_word;
        seed = invert ? ~base : base;
    end
endmodule

// File: rtl/grev_lut_stage.sv
module grev_lut_stage #(
    parameter int WIDTH = 64,
    parameter int CHUNK = 1
) (
    input  logic [WIDTH-1:0] din,
    input  logic             enable,
    input  logic [7:0]       imm,
    output logic [WIDTH-1:0] dout
);
    for (genvar j = 0; j < WIDTH; j++) begin : g_bit
        logic [1:0] idx;
        logic [3:0] tbl;
        if ((j & CHUNK) == 0) begin : g_low
            assign idx = {din[j], din[j + CHUNK]};
            assign tbl = imm[3:0];
        end else begin : g_high
            assign idx = {din[j - CHUNK], din[j]};
            assign tbl = imm[7:4];
        end
        assign dout[j] = enable ? tbl[idx] : din[j];
    end
endmodule

// File: rtl/grev_lut_network.sv
module grev_lut_network #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 6
) (
    input  logic [WIDTH-1:0]  seed,
    input  logic [STAGES-1:0] stage_ctl,
    input  logic [7:0]        imm,
    output logic [WIDTH-1:0]  dout
);
    logic [WIDTH-1:0] chain [0:STAGES];

    assign chain[0] = seed;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        grev_lut_stage #(
            .WIDTH (WIDTH),
            .CHUNK (1 << k)
        ) u_stage (
            .din    (chain[k]),
            .enable (stage_ctl[k]),
            .imm    (imm),
            .dout   (chain[k+1])
        );
    end

    assign dout = chain[STAGES];
endmodule

// File: rtl/grev_lut_unit.sv
module grev_lut_unit
    import grev_lut_pkg::*;
#(
    parameter int WIDTH  = WORD_W,
    parameter int STAGES = STAGE_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WIDTH-1:0]  src_word,
    input  logic              src_is_zero,
    input  logic [STAGES-1:0] stage_ctl,
    input  logic [IMM_W-1:0]  lut_imm,
    input  logic              invert,
    output logic              out_valid,
    output logic [WIDTH-1:0]  result
);
    logic [WIDTH-1:0] seed_w;
    logic [WIDTH-1:0] net_w;
    out_state_t       state_d;
    out_state_t       state_q;

    grev_lut_seed #(.WIDTH(WIDTH)) u_seed (
        .src_word    (src_word),
        .src_is_zero (src_is_zero),
        .invert      (invert),
        .seed        (seed_w)
    );

    grev_lut_network #(.WIDTH(WIDTH), .STAGES(STAGES)) u_net (
        .seed      (seed_w),
        .stage_ctl (stage_ctl),
        .imm       (lut_imm),
        .dout      (net_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.data = net_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.data;
endmodule

// File: rtl/grev_lut_unit_chk.sv
module grev_lut_unit_chk #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WIDTH-1:0]  src_word,
    input logic              src_is_zero,
    input logic [STAGES-1:0] stage_ctl,
    input logic [7:0]        lut_imm,
    input logic              invert,
    input logic              out_valid,
    input logic [WIDTH-1:0]  result
);
    logic [WIDTH-1:0] start_w;
    assign start_w = (src_is_zero ? {(WIDTH/2){2'b01}} : src_word) ^ {WIDTH{invert}};

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R3
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stage_ctl == '0) |=> result == $past(start_w)); // R11
    AST_GREV_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lut_imm == 8'hCA) |=> $countones(result) == $countones($past(start_w))); // R8
    AST_GORC_COVER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lut_imm == 8'hEE) |=> (result & $past(start_w)) == $past(start_w)); // R9
    AST_ZERO_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lut_imm == 8'h00 && stage_ctl != '0) |=> result == '0); // R7
endmodule

bind grev_lut_unit grev_lut_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .src_word    (src_word),
    .src_is_zero (src_is_zero),
    .stage_ctl   (stage_ctl),
    .lut_imm     (lut_imm),
    .invert      (invert),
    .out_valid   (out_valid),
    .result      (result)
);

// File: tb/grev_lut_unit_tb.sv
`timescale 1ns/1ps
module grev_lut_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src_word = '0;
    logic        src_is_zero = 1'b0;
    logic [5:0]  stage_ctl = '0;
    logic [7:0]  lut_imm = '0;
    logic        invert = 1'b0;
    logic        out_valid;
    logic [63:0] result;

    int n_vec  = 0;
    int n_fail = 0;
    logic [63:0] lcg = 64'h0123_4567_89AB_CDEF;

    always #4 clk = ~clk;

    grev_lut_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_word(src_word),
        .src_is_zero(src_is_zero), .stage_ctl(stage_ctl), .lut_imm(lut_imm),
        .invert(invert), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] start_of(logic [63:0] s, logic z, logic iv);
        logic [63:0] b = z ? 64'h5555_5555_5555_5555 : s;
        return iv ? ~b : b;
    endfunction

    // bit-by-bit table model (R6, R7)
    function automatic logic [63:0] ref_lut(logic [63:0] x0, logic [5:0] c, logic [7:0] imm);
        logic [63:0] x = x0;
        for (int k = 0; k < 6; k++) begin
            if (c[k]) begin
                logic [63:0] y;
                int ch = 1 << k;
                for (int j = 0; j < 64; j++) begin
                    int lo_pos = (j & ch) == 0 ? j : j - ch;
                    int idx = 2 * int'(x[lo_pos]) + int'(x[lo_pos + ch]);
                    y[j] = ((j & ch) == 0) ? imm[idx] : imm[4 + idx];
                end
                x = y;
            end
        end
        return x;
    endfunction

    function automatic logic [63:0] low_mask(int ch);
        logic [63:0] m;
        for (int j = 0; j < 64; j++) m[j] = ((j & ch) == 0);
        return m;
    endfunction

    function automatic logic [63:0] ref_grev(logic [63:0] x0, logic [5:0] c, bit orc);
        logic [63:0] x = x0;
        for (int k = 0; k < 6; k++) begin
            if (c[k]) begin
                int ch = 1 << k;
                logic [63:0] m = low_mask(ch);
                logic [63:0] sw = ((x & m) << ch) | ((x & ~m) >> ch);
                x = orc ? (x | sw) : sw;
            end
        end
        return x;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(logic [63:0] s, logic z, logic [5:0] c, logic [7:0] imm, logic iv);
        @(negedge clk);
        src_word = s; src_is_zero = z; stage_ctl = c; lut_imm = imm; invert = iv;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic step_lcg();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", result, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle valid", {63'd0, out_valid}, 64'd0);
        check("R1 idle result", result, 64'd0);

        // R10 mask constants
        apply('0, 1'b1, 6'b000010, 8'h6C, 1'b0); check("R10 a", result, 64'h1111_1111_1111_1111);
        apply('0, 1'b1, 6'b000110, 8'h6C, 1'b0); check("R10 b", result, 64'h0101_0101_0101_0101);
        apply('0, 1'b1, 6'b001110, 8'h6C, 1'b0); check("R10 c", result, 64'h0001_0001_0001_0001);
        apply('0, 1'b1, 6'b000010, 8'hC6, 1'b1); check("R10 d", result, 64'h8888_8888_8888_8888);
        apply('0, 1'b1, 6'b000110, 8'hC6, 1'b1); check("R10 e", result, 64'h8080_8080_8080_8080);
        apply('0, 1'b1, 6'b001110, 8'hC6, 1'b1); check("R10 f", result, 64'h8000_8000_8000_8000);

        // R4 / R5 seed with bypass (R11)
        apply(64'hDEAD_BEEF_0000_FFFF, 1'b1, 6'd0, 8'h00, 1'b0); check("R4 seed", result, 64'h5555_5555_5555_5555);
        apply(64'hDEAD_BEEF_0000_FFFF, 1'b0, 6'd0, 8'h00, 1'b0); check("R4 src", result, 64'hDEAD_BEEF_0000_FFFF);
        apply(64'hDEAD_BEEF_0000_FFFF, 1'b1, 6'd0, 8'hFF, 1'b1); check("R5 seed inv", result, 64'hAAAA_AAAA_AAAA_AAAA);
        apply(64'hDEAD_BEEF_0000_FFFF, 1'b0, 6'd0, 8'h5A, 1'b1); check("R5 src inv", result, 64'h2152_4110_FFFF_0000);

        // R2 strobe latency and valid pulse
        @(negedge clk);
        src_word = 64'h1; src_is_zero = 1'b0; stage_ctl = 6'b100000; lut_imm = 8'hCA; invert = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid", {63'd0, out_valid}, 64'd1);
        check("R2 data", result, 64'h0000_0001_0000_0000);
        @(negedge clk);
        check("R2 valid drop", {63'd0, out_valid}, 64'd0);

        // R3 inputs ignored without strobe
        src_word = 64'hFFFF_0000_FFFF_0000; stage_ctl = 6'h3F; lut_imm = 8'hFF; invert = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 hold", result, 64'h0000_0001_0000_0000);

        // R8 / R9 against shift-mask formulas
        for (int c = 0; c < 64; c++) begin
            for (int n = 0; n < 4; n++) begin
                logic [63:0] st;
                step_lcg();
                st = start_of(lcg, lcg[3], lcg[7]);
                apply(lcg, lcg[3], 6'(c), 8'hCA, lcg[7]);
                check("R8 grev", result, ref_grev(st, 6'(c), 1'b0));
                step_lcg();
                st = start_of(lcg, lcg[5], lcg[9]);
                apply(lcg, lcg[5], 6'(c), 8'hEE, lcg[9]);
                check("R9 gorc", result, ref_grev(st, 6'(c), 1'b1));
            end
        end

        // R6 / R7 full immediate x control sweep
        for (int imm = 0; imm < 256; imm++) begin
            for (int c = 0; c < 64; c++) begin
                logic [63:0] st;
                step_lcg();
                st = start_of(lcg, lcg[11] & lcg[12], lcg[13]);
                apply(lcg, lcg[11] & lcg[12], 6'(c), 8'(imm), lcg[13]);
                check(c == 0 ? "R11 bypass" : "R7 table", result, ref_lut(st, 6'(c), 8'(imm)));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule